// File: doc/BRIEF.md
# Indexed-register cartridge bank mapper

This block is the banking controller of a cartridge on an 8-bit console bus. The CPU reaches a file of eight 3-bit registers through two decoded ports. A write to the index port picks a register. A read or write on the data port then reaches that register. Each of the eight registers keeps all three of its bits, and every bit can be read back.

Some register fields drive the upper address lines of the program ROM and the character ROM. One field drives the video-RAM page select for the four nametable quadrants. The bank lines for character ROM are put together from fields in three different registers. Registers 0, 1 and 3 only store data. Among the mirroring arrangements is an L-shaped layout, in which the lower-right quadrant is the only one with a page of its own.

Top module: `cart_bank_mapper`

## Requirements
- R1: A bus access hits the index port when (cpu_addr AND 0xC101) equals 0x4100, and hits the data port when the masked address equals 0x4101. No other address has any effect. The index port is write-only.
- R2: An index-port write stores cpu_wdata[2:0] as the selected register number. A data-port write stores cpu_wdata[2:0] into the selected register. Every bit of all eight registers reads back as it was written.
- R3: While a data-port read is in progress (cpu_strobe=1, cpu_rw=1), cpu_rdata[2:0] shows the selected register, cpu_rdata[7:3] is zero and cpu_rdata_oe is 1. In every other cycle cpu_rdata_oe is 0 and cpu_rdata is zero.
- R4: prg_bank[1:0] (program address lines A16..A15, selecting a 32 KiB bank) equals register 5 bits 1:0.
- R5: chr_bank[3:0] (character address lines A16..A13, selecting an 8 KiB bank) equals {register 6 bits 1:0, register 4 bit 0, register 2 bit 0}.
- R6: Register 7 bits 2:1 set the mode of ciram_page:
  - 0: ciram_page = ppu_a11 AND ppu_a10 (the L-shaped layout).
  - 1: ciram_page = ppu_a11 (horizontal).
  - 2: ciram_page = ppu_a10 (vertical).
  - 3: ciram_page = 1.
- R7: Registers 0, 1 and 3 have no effect on any bank or page output. The same holds for every register bit not named in R4 to R6.
- R8: An asserted rst_n clears the index and all eight registers at once. After reset, prg_bank=0, chr_bank=0 and mode 0 is in force.
- R9: A register changes only at a clock edge where a decoded write is present (cpu_strobe=1, cpu_rw=0). The bank outputs show the new value from the following cycle on. A cycle with cpu_strobe=0, or an index-port read, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_strobe | input | 1 | The bus access is valid in this cycle |
| ppu_a11 | input | 1 | PPU address bit 11 (nametable row) |
| ppu_a10 | input | 1 | PPU address bit 10 (nametable column) |
| cpu_rdata | output | 8 | Read-back data |
| cpu_rdata_oe | output | 1 | Read-back data is driven |
| prg_bank | output | 2 | Program ROM A16..A15 |
| chr_bank | output | 4 | Character ROM A16..A13 |
| ciram_page | output | 1 | Video RAM page for the current quadrant |

## Verification
The bench aims at the following corner cases:
- Mirror addresses inside the mask and near-miss addresses outside it. A decoder that compares too many bits would miss the mirrors. One that compares too few would take writes meant for other addresses.
- Patterns written to the unused registers and to the unused bits. A mapper that wires the wrong register would move the character bank. One that drops the stored bits would return zeros on readback.
- All four quadrants in every mirroring mode. The L-shaped mode, which gives page 1 only when both PPU bits are 1, is the easy one to confuse with single-screen or with vertical mirroring.
- Reads of the index port, writes with the strobe low, and a reset in the middle of the run. These catch stray writes and read strobes left asserted.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int unsigned PRG_W = 2;
  localparam int unsigned CHR_W = 4;

  typedef enum logic [1:0] {
    NT_LSHAPE = 2'd0,
    NT_HORZ   = 2'd1,
    NT_VERT   = 2'd2,
    NT_SINGLE = 2'd3
  } nt_mode_e;

  typedef struct packed {
    logic idx_wr;
    logic dat_wr;
    logic dat_rd;
  } bus_op_t;
endpackage

// File: rtl/mapper_rst_sync.sv
module mapper_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mapper_bus_decode.sv
module mapper_bus_decode
  import mapper_pkg::*;
#(
  parameter int unsigned           ADDR_W      = 16,
  parameter logic [ADDR_W-1:0]     DECODE_MASK = 16'hC101,
  parameter logic [ADDR_W-1:0]     INDEX_MATCH = 16'h4100,
  parameter logic [ADDR_W-1:0]     DATA_MATCH  = 16'h4101
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              cpu_strobe,
  output bus_op_t           op
);
  logic [ADDR_W-1:0] masked;
  logic              hit_idx;
  logic              hit_dat;

  always_comb begin
    masked    = cpu_addr & DECODE_MASK;
    hit_idx   = (masked == INDEX_MATCH);
    hit_dat   = (masked == DATA_MATCH);
    op.idx_wr = cpu_strobe & ~cpu_rw & hit_idx;
    op.dat_wr = cpu_strobe & ~cpu_rw & hit_dat;
    op.dat_rd = cpu_strobe &  cpu_rw & hit_dat;
  end
endmodule

// File: rtl/mapper_reg_file.sv
module mapper_reg_file
  import mapper_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 3,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  bus_op_t                        op,
  input  logic [REG_W-1:0]               wdata,
  output logic [IDX_W-1:0]               idx_o,
  output logic [NUM_REGS-1:0][REG_W-1:0] regs_o,
  output logic [REG_W-1:0]               rd_val
);
  logic [IDX_W-1:0]    idx_q;
  logic [IDX_W-1:0]    idx_d;
  logic                idx_en;
  logic [NUM_REGS-1:0] reg_en;

  always_comb begin
    idx_en = op.idx_wr;
    idx_d  = wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      logic [REG_W-1:0] val_q;
      assign reg_en[gi] = op.dat_wr && (idx_q == IDX_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          val_q <= '0;
        else if (reg_en[gi]) val_q <= wdata;
      end
      assign regs_o[gi] = val_q;
    end
  endgenerate

  assign idx_o  = idx_q;
  assign rd_val = regs_o[idx_q];
endmodule

// File: rtl/mapper_bank_map.sv
module mapper_bank_map
  import mapper_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned REG_W       = 3,
  parameter int unsigned PRG_REG     = 5,
  parameter int unsigned CHR_A13_REG = 2,
  parameter int unsigned CHR_A14_REG = 4,
  parameter int unsigned CHR_HI_REG  = 6,
  parameter int unsigned NT_REG      = 7
) (
  input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
  input  logic                           ppu_a11,
  input  logic                           ppu_a10,
  output logic [PRG_W-1:0]               prg_bank,
  output logic [CHR_W-1:0]               chr_bank,
  output nt_mode_e                       nt_mode,
  output logic                           ciram_page
);
  always_comb begin
    prg_bank = regs[PRG_REG][1:0];
    chr_bank = {regs[CHR_HI_REG][1:0], regs[CHR_A14_REG][0], regs[CHR_A13_REG][0]};
    nt_mode  = nt_mode_e'(regs[NT_REG][2:1]);
    unique case (nt_mode)
      NT_LSHAPE: ciram_page = ppu_a11 & ppu_a10;
      NT_HORZ:   ciram_page = ppu_a11;
      NT_VERT:   ciram_page = ppu_a10;
      default:   ciram_page = 1'b1;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{regs[0], regs[1], regs[3], regs[CHR_A13_REG][2:1],
                         regs[CHR_A14_REG][2:1], regs[PRG_REG][2],
                         regs[CHR_HI_REG][2], regs[NT_REG][0]};
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import mapper_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 16,
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       NUM_REGS    = 8,
  parameter int unsigned       REG_W       = 3,
  parameter int unsigned       RST_STAGES  = 2,
  parameter logic [ADDR_W-1:0] DECODE_MASK = 16'hC101,
  parameter logic [ADDR_W-1:0] INDEX_MATCH = 16'h4100,
  parameter logic [ADDR_W-1:0] DATA_MATCH  = 16'h4101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rw,
  input  logic              cpu_strobe,
  input  logic              ppu_a11,
  input  logic              ppu_a10,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe,
  output logic [PRG_W-1:0]  prg_bank,
  output logic [CHR_W-1:0]  chr_bank,
  output logic              ciram_page
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic                           rst_sync_n;
  bus_op_t                        op;
  logic [IDX_W-1:0]               idx_q;
  logic [NUM_REGS-1:0][REG_W-1:0] regs;
  logic [REG_W-1:0]               rd_val;
  nt_mode_e                       nt_mode;

  mapper_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mapper_bus_decode #(
    .ADDR_W      (ADDR_W),
    .DECODE_MASK (DECODE_MASK),
    .INDEX_MATCH (INDEX_MATCH),
    .DATA_MATCH  (DATA_MATCH)
  ) u_dec (
    .cpu_addr   (cpu_addr),
    .cpu_rw     (cpu_rw),
    .cpu_strobe (cpu_strobe),
    .op         (op)
  );

  mapper_reg_file #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_rf (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .op     (op),
    .wdata  (cpu_wdata[REG_W-1:0]),
    .idx_o  (idx_q),
    .regs_o (regs),
    .rd_val (rd_val)
  );

  mapper_bank_map #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_map (
    .regs       (regs),
    .ppu_a11    (ppu_a11),
    .ppu_a10    (ppu_a10),
    .prg_bank   (prg_bank),
    .chr_bank   (chr_bank),
    .nt_mode    (nt_mode),
    .ciram_page (ciram_page)
  );

  always_comb begin
    cpu_rdata_oe = op.dat_rd;
    cpu_rdata    = op.dat_rd ? {{(DATA_W-REG_W){1'b0}}, rd_val} : '0;
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^cpu_wdata[DATA_W-1:REG_W];
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker (
  input logic        clk,
  input logic        rst_q_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_rw,
  input logic        cpu_strobe,
  input logic        ppu_a11,
  input logic [7:0]  cpu_rdata,
  input logic        cpu_rdata_oe,
  input logic [1:0]  prg_bank,
  input logic [3:0]  chr_bank,
  input logic        ciram_page,
  input logic [2:0]  cur_idx,
  input logic [1:0]  nt_mode
);
  logic wr_cyc;
  logic dat_wr_cyc;
  assign wr_cyc     = cpu_strobe && !cpu_rw;
  assign dat_wr_cyc = wr_cyc && ((cpu_addr & 16'hC101) == 16'h4101);

  always_comb begin
    if (rst_q_n) begin
      AST_RDATA_HIGH_ZERO: assert (cpu_rdata[7:3] == 5'd0); // R3
      AST_IDLE_RDATA_ZERO: assert (cpu_rdata_oe || cpu_rdata == 8'd0); // R3
    end
  end

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_q_n)
    cpu_rdata_oe |-> (cpu_strobe && cpu_rw)); // R3
  AST_PRG_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dat_wr_cyc && cur_idx == 3'd5) |=> (prg_bank == $past(cpu_wdata[1:0]))); // R4
  AST_ONE_SCREEN_HIGH: assert property (@(posedge clk) disable iff (!rst_q_n)
    (nt_mode == 2'd3) |-> ciram_page); // R6
  AST_LSHAPE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (nt_mode == 2'd0 && !ppu_a11) |-> !ciram_page); // R6
  AST_SPARE_REG_INERT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dat_wr_cyc && (cur_idx == 3'd0 || cur_idx == 3'd1 || cur_idx == 3'd3))
    |=> ($stable(prg_bank) && $stable(chr_bank) && $stable(nt_mode))); // R7
  AST_BANKS_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wr_cyc |=> ($stable(prg_bank) && $stable(chr_bank) && $stable(nt_mode))); // R9
endmodule

bind cart_bank_mapper mapper_checker u_chk (
  .clk          (clk),
  .rst_q_n      (rst_sync_n),
  .cpu_addr     (cpu_addr),
  .cpu_wdata    (cpu_wdata),
  .cpu_rw       (cpu_rw),
  .cpu_strobe   (cpu_strobe),
  .ppu_a11      (ppu_a11),
  .cpu_rdata    (cpu_rdata),
  .cpu_rdata_oe (cpu_rdata_oe),
  .prg_bank     (prg_bank),
  .chr_bank     (chr_bank),
  .ciram_page   (ciram_page),
  .cur_idx      (idx_q),
  .nt_mode      (nt_mode)
);

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/1ps
module sim_cart_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rw = 1'b1;
  logic        cpu_strobe = 1'b0;
  logic        ppu_a11 = 1'b0;
  logic        ppu_a10 = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rdata_oe;
  logic [1:0]  prg_bank;
  logic [3:0]  chr_bank;
  logic        ciram_page;

  int unsigned nchk = 0;
  int unsigned nfail = 0;
  bit          done = 0;
  logic [2:0]  exp_regs [8];
  logic [2:0]  exp_idx;
  int unsigned seed_val;

  always #2 clk = ~clk;

  cart_bank_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rw(cpu_rw), .cpu_strobe(cpu_strobe), .ppu_a11(ppu_a11), .ppu_a10(ppu_a10),
    .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe), .prg_bank(prg_bank),
    .chr_bank(chr_bank), .ciram_page(ciram_page)
  );

  function automatic logic f_idx_hit(input logic [15:0] a);
    return (a & 16'hC101) == 16'h4100;
  endfunction
  function automatic logic f_dat_hit(input logic [15:0] a);
    return (a & 16'hC101) == 16'h4101;
  endfunction
  function automatic logic [3:0] f_chr();
    return {exp_regs[6][1:0], exp_regs[4][0], exp_regs[2][0]};
  endfunction
  function automatic logic f_page(input logic [1:0] m, input logic a11, input logic a10);
    case (m)
      2'd0: return a11 & a10;
      2'd1: return a11;
      2'd2: return a10;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) exp_regs[i] = 3'd0;
    exp_idx = 3'd0;
  endtask

  task automatic step(input logic stb, input logic rw, input logic [15:0] a,
                      input logic [7:0] d, input logic p11, input logic p10);
    logic rd;
    @(negedge clk);
    check("R4 prg_bank", {30'd0, prg_bank}, {30'd0, exp_regs[5][1:0]});
    check("R5 chr_bank", {28'd0, chr_bank}, {28'd0, f_chr()});
    cpu_strobe = stb; cpu_rw = rw; cpu_addr = a; cpu_wdata = d;
    ppu_a11 = p11; ppu_a10 = p10;
    #1;
    check("R6 ciram_page", {31'd0, ciram_page}, {31'd0, f_page(exp_regs[7][2:1], p11, p10)});
    rd = stb && rw && f_dat_hit(a);
    check("R3 rdata_oe", {31'd0, cpu_rdata_oe}, {31'd0, rd});
    check("R3 rdata", {24'd0, cpu_rdata}, rd ? {29'd0, exp_regs[exp_idx]} : 32'd0);
    @(posedge clk);
    if (stb && !rw) begin
      if (f_idx_hit(a))      exp_idx = d[2:0];
      else if (f_dat_hit(a)) exp_regs[exp_idx] = d[2:0];
    end
  endtask

  task automatic wr_reg(input logic [2:0] r, input logic [7:0] v);
    step(1'b1, 1'b0, 16'h4100, {5'd0, r}, 1'b0, 1'b0);
    step(1'b1, 1'b0, 16'h4101, v, 1'b0, 1'b0);
  endtask

  task automatic rd_reg(input logic [2:0] r);
    step(1'b1, 1'b0, 16'h4100, {5'd0, r}, 1'b0, 1'b0);
    step(1'b1, 1'b1, 16'h4101, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    seed_val = $urandom(32'h00C0FFEE);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: outputs while reset is held
    check("R8 prg in reset", {30'd0, prg_bank}, 32'd0);
    check("R8 chr in reset", {28'd0, chr_bank}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R8: every register reads zero after reset
    for (int r = 0; r < 8; r++) rd_reg(3'(r));

    // R2: full three-bit readback in all registers
    for (int r = 0; r < 8; r++) wr_reg(3'(r), 8'hF8 | 8'(7 - r));
    for (int r = 0; r < 8; r++) rd_reg(3'(r));

    // R7: spare registers and spare bits leave the banks alone
    wr_reg(3'd2, 8'h06);
    wr_reg(3'd4, 8'h06);
    wr_reg(3'd0, 8'h07);
    wr_reg(3'd1, 8'h05);
    wr_reg(3'd3, 8'h03);
    step(1'b0, 1'b0, 16'h4100, 8'h00, 1'b0, 1'b0);

    // R6: every mode over all four quadrants
    for (int m = 0; m < 4; m++) begin
      wr_reg(3'd7, 8'(m << 1));
      for (int q = 0; q < 4; q++) step(1'b0, 1'b1, 16'h0000, 8'h00, q[1], q[0]);
    end

    // R1: mirrors within the mask, near misses outside it
    step(1'b1, 1'b0, 16'h7FFE, 8'h05, 1'b0, 1'b0);
    step(1'b1, 1'b0, 16'h5F01, 8'h03, 1'b0, 1'b0);
    step(1'b1, 1'b0, 16'h8101, 8'h00, 1'b0, 1'b0);
    step(1'b1, 1'b0, 16'h4001, 8'h00, 1'b0, 1'b0);
    step(1'b1, 1'b1, 16'h4101, 8'h00, 1'b0, 1'b0);
    // R9: index read, strobe-low write
    step(1'b1, 1'b1, 16'h4100, 8'h00, 1'b0, 1'b0);
    step(1'b0, 1'b0, 16'h4101, 8'h00, 1'b0, 1'b0);
    step(1'b1, 1'b1, 16'h4101, 8'h00, 1'b0, 1'b0);

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      logic [2:0]  sel;
      sel = 3'($urandom % 8);
      a   = 16'($urandom);
      if (sel < 3)      a = (a & ~16'hC101) | 16'h4100;
      else if (sel < 6) a = (a & ~16'hC101) | 16'h4101;
      step(($urandom % 8) != 0, $urandom % 2 == 1, a, 8'($urandom),
           $urandom % 2 == 1, $urandom % 2 == 1);
    end

    // R8: asynchronous reset in mid-run
    wr_reg(3'd5, 8'h03);
    wr_reg(3'd6, 8'h03);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_reset();
    check("R8 prg async clear", {30'd0, prg_bank}, 32'd0);
    check("R8 chr async clear", {28'd0, chr_bank}, 32'd0);
    cpu_strobe = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    for (int r = 0; r < 8; r++) rd_reg(3'(r));

    done = 1;
    summary();
    $finish;
  end
endmodule